// File: doc/BRIEF.md
# Interrupt Pin Unit with Edge-Triggered General-Purpose Inputs

This block collects interrupt requests from a set of raw event lines and from eight general-purpose input pins, holds each request in a sticky flag, and drives one interrupt pin. Each general-purpose input is synchronized and raises its request on a rising or a falling transition, chosen per pin. Software clears flags by writing ones to their positions. A per-request enable and a global enable decide whether a pending flag can reach the pin. A disabled flag is still recorded.

The pin is modelled as a data value plus an output enable, and its style is chosen at run time. In level mode it behaves as an open-drain, active-low output: it pulls low while any enabled request is pending, and floats otherwise. In edge mode it is driven at all times. It rests at its inactive level and emits a pulse of programmable polarity and fixed length whenever the set of enabled pending requests gains a member.

Top module: `irq_out_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, every request flag reads 0, `irq_oe_o` is 0 and `irq_o` is 0.
- R2: A high level on `evt_i[k]` at a rising clock edge sets flag `req_o[k]`, which reads 1 from the next cycle. The flag then stays set until it is acknowledged.
- R3: When `ack_we_i` is high, each flag whose bit in `ack_i` is 1 is cleared at that edge. Flags whose bit is 0 are left as they are.
- R4: If a flag is set by an event and acknowledged at the same edge, the set wins and the flag reads 1 afterwards.
- R5: General-purpose input `gpin_i[j]` passes through two synchronizer flops and sets flag `req_o[N_EVT+j]`. With `gpin_rise_i[j]`=1 only a rising transition sets it, and with 0 only a falling transition sets it. The opposite transition leaves the flag unchanged.
- R6: A flag whose bit in `en_i` is 0 still latches, but it never activates the pin. Setting the enable later makes the held flag take effect.
- R7: With `glob_en_i`=0 the pin never becomes active. In level mode `irq_oe_o` stays 0, and in edge mode `irq_o` stays at the inactive level.
- R8: In level mode (`edge_mode_i`=0), `irq_o` is 0. `irq_oe_o` is 1 from the cycle after an enabled flag becomes visible until the cycle after no enabled flag remains, and 0 otherwise.
- R9: In edge mode (`edge_mode_i`=1), `irq_oe_o` is 1. `irq_o` rests at `~edge_pol_i` and shows `edge_pol_i` for exactly PULSE_LEN cycles each time a flag joins the set of enabled pending flags. This includes a flag that joins while others are still pending.
- R10: In edge mode, if an acknowledge clears every enabled pending flag during a pulse, the pin returns to `~edge_pol_i` no later than the second cycle after the acknowledge edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_EVT | Raw event lines, sampled at each edge |
| gpin_i | input | N_GPIN | Asynchronous general-purpose inputs |
| gpin_rise_i | input | N_GPIN | Per-pin trigger edge: 1 rising, 0 falling |
| en_i | input | N_EVT+N_GPIN | Per-request enable |
| glob_en_i | input | 1 | Global interrupt enable |
| edge_mode_i | input | 1 | Pin style: 0 open-drain level, 1 push-pull pulse |
| edge_pol_i | input | 1 | Active level of the pulse in edge mode |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_i | input | N_EVT+N_GPIN | Write-one-to-clear mask |
| req_o | output | N_EVT+N_GPIN | Sticky request flags; events low, inputs high |
| irq_o | output | 1 | Pin data value |
| irq_oe_o | output | 1 | Pin output enable |

## Verification
Setting a flag and clearing it can fall on the same clock edge. The bench provokes this by raising an event line in the same cycle as an acknowledge strobe whose mask has a 1 for that flag. It judges the outcome by reading the flag and the level-mode output enable once the edge has passed: both must show the request as still pending. A second overlap sets a new request while another is still pending in edge mode. That case is judged by counting a full fresh pulse.

// File: rtl/irqo_pkg.sv
package irqo_pkg;
  typedef enum logic {
    PIN_OPEN_DRAIN = 1'b0,
    PIN_PULSED     = 1'b1
  } pin_style_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/irqo_gpin_edge.sv
module irqo_gpin_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] hit_o
);
  // two synchronizer stages plus one history stage
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_det
    assign hit_o[k] = rise_sel_i[k] ? (sync_q[k] & ~hist_q[k])
                                    : (~sync_q[k] & hist_q[k]);
  end
endmodule

// File: rtl/irqo_flags.sv
module irqo_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] clr_mask;

  always_comb clr_mask = clr_we_i ? clr_i : '0;

  // a new event outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) flag_o <= '0;
    else     flag_o <= (flag_o & ~clr_mask) | set_i;
  end
endmodule

// File: rtl/irqo_pin.sv
module irqo_pin
  import irqo_pkg::*;
#(
  parameter int W         = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend_i,
  input  logic         edge_mode_i,
  input  logic         edge_pol_i,
  output logic         irq_o,
  output logic         irq_oe_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  pin_style_e   style;
  logic [W-1:0] pend_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic         gain;

  always_comb begin
    style = pin_style_e'(edge_mode_i);
    gain  = |(pend_i & ~pend_q);
    if (gain)                cnt_n = CW'(PULSE_LEN);
    else if (pend_i == '0)   cnt_n = '0;
    else if (cnt_q != '0)    cnt_n = cnt_q - CW'(1);
    else                     cnt_n = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      cnt_q    <= '0;
      irq_o    <= 1'b0;
      irq_oe_o <= 1'b0;
    end else begin
      pend_q <= pend_i;
      cnt_q  <= cnt_n;
      if (style == PIN_PULSED) begin
        irq_oe_o <= 1'b1;
        irq_o    <= (cnt_n != '0) ? edge_pol_i : ~edge_pol_i;
      end else begin
        irq_oe_o <= |pend_i;
        irq_o    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_out_unit.sv
module irq_out_unit #(
  parameter int N_EVT     = 8,
  parameter int N_GPIN    = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_EVT-1:0]        evt_i,
  input  logic [N_GPIN-1:0]       gpin_i,
  input  logic [N_GPIN-1:0]       gpin_rise_i,
  input  logic [N_EVT+N_GPIN-1:0] en_i,
  input  logic                    glob_en_i,
  input  logic                    edge_mode_i,
  input  logic                    edge_pol_i,
  input  logic                    ack_we_i,
  input  logic [N_EVT+N_GPIN-1:0] ack_i,
  output logic [N_EVT+N_GPIN-1:0] req_o,
  output logic                    irq_o,
  output logic                    irq_oe_o
);
  localparam int TOT = N_EVT + N_GPIN;

  logic [N_GPIN-1:0] gpin_hit;
  logic [TOT-1:0]    set_vec;
  logic [TOT-1:0]    pend;

  irqo_gpin_edge #(.W(N_GPIN)) u_gpin (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (gpin_i),
    .rise_sel_i (gpin_rise_i),
    .hit_o      (gpin_hit)
  );

  assign set_vec = {gpin_hit, evt_i};

  irqo_flags #(.W(TOT)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_vec),
    .clr_we_i (ack_we_i),
    .clr_i    (ack_i),
    .flag_o   (req_o)
  );

  assign pend = glob_en_i ? (req_o & en_i) : '0;

  irqo_pin #(.W(TOT), .PULSE_LEN(PULSE_LEN)) u_pin (
    .clk         (clk),
    .rst         (rst),
    .pend_i      (pend),
    .edge_mode_i (edge_mode_i),
    .edge_pol_i  (edge_pol_i),
    .irq_o       (irq_o),
    .irq_oe_o    (irq_oe_o)
  );
endmodule

// File: rtl/irq_out_unit_chk.sv
module irq_out_unit_chk #(
  parameter int TOT = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [TOT-1:0] en_i,
  input logic           glob_en_i,
  input logic           edge_mode_i,
  input logic           ack_we_i,
  input logic [TOT-1:0] req_o,
  input logic           irq_o,
  input logic           irq_oe_o
);
  // R2: without an acknowledge no flag can drop
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !ack_we_i |=> ((req_o & $past(req_o)) == $past(req_o)));

  // R6: nothing enabled pending means the level pin floats
  p_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode_i && ((req_o & en_i) == '0)) |=> !irq_oe_o);

  // R7: global enable off keeps the level pin released
  p_global_r7: assert property (@(posedge clk) disable iff (rst)
    (!glob_en_i && !edge_mode_i) |=> !irq_oe_o);

  // R8: level mode only ever pulls low
  p_level_low_r8: assert property (@(posedge clk) disable iff (rst)
    !edge_mode_i |=> !irq_o);

  // R9: edge mode always drives the pin
  p_edge_drive_r9: assert property (@(posedge clk) disable iff (rst)
    edge_mode_i |=> irq_oe_o);
endmodule

bind irq_out_unit irq_out_unit_chk #(.TOT(N_EVT + N_GPIN)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .glob_en_i   (glob_en_i),
  .edge_mode_i (edge_mode_i),
  .ack_we_i    (ack_we_i),
  .req_o       (req_o),
  .irq_o       (irq_o),
  .irq_oe_o    (irq_oe_o)
);

// File: tb/irq_out_unit_tb.sv
module irq_out_unit_tb_top;
  localparam int NE = 8;
  localparam int NG = 8;
  localparam int PL = 4;
  localparam int T  = NE + NG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] evt_i = '0;
  logic [NG-1:0] gpin_i = '0;
  logic [NG-1:0] gpin_rise_i = '0;
  logic [T-1:0]  en_i = '0;
  logic          glob_en_i = 1'b0;
  logic          edge_mode_i = 1'b0;
  logic          edge_pol_i = 1'b0;
  logic          ack_we_i = 1'b0;
  logic [T-1:0]  ack_i = '0;
  logic [T-1:0]  req_o;
  logic          irq_o, irq_oe_o;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  irq_out_unit #(.N_EVT(NE), .N_GPIN(NG), .PULSE_LEN(PL)) dut_i (
    .clk(clk), .rst(rst), .evt_i(evt_i), .gpin_i(gpin_i),
    .gpin_rise_i(gpin_rise_i), .en_i(en_i), .glob_en_i(glob_en_i),
    .edge_mode_i(edge_mode_i), .edge_pol_i(edge_pol_i),
    .ack_we_i(ack_we_i), .ack_i(ack_i), .req_o(req_o),
    .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  // level-mode table: event, acknowledge, expected flags, expected oe
  localparam logic [48:0] VECS [0:7] = '{
    {16'h0001, 16'h0000, 16'h0001, 1'b1},  // R2 first set
    {16'h0004, 16'h0000, 16'h0005, 1'b1},  // R2 accumulate
    {16'h0000, 16'h0001, 16'h0004, 1'b1},  // R3 partial clear
    {16'h0000, 16'h0004, 16'h0000, 1'b0},  // R3 R8 all clear
    {16'h0002, 16'h0002, 16'h0002, 1'b1},  // R4 set wins
    {16'h0000, 16'h00FF, 16'h0000, 1'b0},  // R3 clear
    {16'h0080, 16'h0000, 16'h0080, 1'b1},  // R2 top event bit
    {16'h0000, 16'h0080, 16'h0000, 1'b0}   // R8 release
  };

  task automatic check(input string req, input logic [T-1:0] act, input logic [T-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle stimulus, then sample after the pin register has updated
  task automatic step(input logic [T-1:0] evt, input logic [T-1:0] ack);
    @(negedge clk);
    evt_i    = evt[NE-1:0];
    ack_i    = ack;
    ack_we_i = |ack;
    @(negedge clk);
    evt_i    = '0;
    ack_i    = '0;
    ack_we_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_active(input int win, input logic pol, output int cnt);
    cnt = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (irq_o === pol) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check("R1 flags", req_o, '0);
    check("R1 oe", T'(irq_oe_o), '0);
    check("R1 data", T'(irq_o), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after release", T'(irq_oe_o), '0);

    glob_en_i = 1'b1;
    en_i      = 16'h00FF;
    for (int v = 0; v < 8; v++) begin
      step(VECS[v][48:33], VECS[v][32:17]);
      check($sformatf("R2/R3/R4 vec%0d flags", v), req_o, VECS[v][16:1]);
      check($sformatf("R8 vec%0d oe", v), T'(irq_oe_o), T'(VECS[v][0]));
      check($sformatf("R8 vec%0d data", v), T'(irq_o), '0);
    end

    // R6 disabled flag latches without effect, then takes effect
    en_i = 16'h00FE;
    step(16'h0001, '0);
    check("R6 latched", req_o, 16'h0001);
    check("R6 no pin", T'(irq_oe_o), '0);
    en_i = 16'h00FF;
    @(negedge clk);
    check("R6 enabled later", T'(irq_oe_o), 16'h0001);
    step('0, 16'hFFFF);

    // R7 global enable off
    glob_en_i = 1'b0;
    step(16'h0002, '0);
    check("R7 flag", req_o, 16'h0002);
    check("R7 level oe", T'(irq_oe_o), '0);
    step('0, 16'hFFFF);

    // R5 input edges: pin0 rising, pin1 falling
    glob_en_i   = 1'b1;
    en_i        = 16'hFF00;
    gpin_rise_i = 8'h01;
    @(negedge clk);
    gpin_i = 8'h03;
    repeat (5) @(negedge clk);
    check("R5 rise on pin0 only", req_o, 16'h0100);
    check("R5 oe", T'(irq_oe_o), 16'h0001);
    step('0, 16'hFF00);
    check("R5 cleared", req_o, '0);
    gpin_i = 8'h00;
    repeat (5) @(negedge clk);
    check("R5 fall on pin1 only", req_o, 16'h0200);
    step('0, 16'hFFFF);

    // R9 edge mode, active high
    en_i        = 16'hFFFF;
    edge_mode_i = 1'b1;
    edge_pol_i  = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 idle oe", T'(irq_oe_o), 16'h0001);
    check("R9 idle level", T'(irq_o), '0);
    @(negedge clk); evt_i = 8'h04;
    @(negedge clk); evt_i = '0;
    count_active(12, 1'b1, c);
    check("R9 pulse length high", T'(c), T'(PL));
    @(negedge clk); evt_i = 8'h08;
    @(negedge clk); evt_i = '0;
    count_active(12, 1'b1, c);
    check("R9 retrigger while pending", T'(c), T'(PL));

    // R7 edge mode with global enable off
    step('0, 16'hFFFF);
    glob_en_i = 1'b0;
    @(negedge clk); evt_i = 8'h10;
    @(negedge clk); evt_i = '0;
    count_active(12, 1'b1, c);
    check("R7 edge no pulse", T'(c), '0);
    step('0, 16'hFFFF);
    glob_en_i = 1'b1;

    // R9 active low
    edge_pol_i = 1'b0;
    @(negedge clk); evt_i = 8'h10;
    @(negedge clk); evt_i = '0;
    count_active(12, 1'b0, c);
    check("R9 pulse length low", T'(c), T'(PL));
    step('0, 16'hFFFF);

    // R10 acknowledge cuts the pulse short
    @(negedge clk); evt_i = 8'h20;
    @(negedge clk); evt_i = '0;
    @(negedge clk);
    check("R10 pulse started", T'(irq_o), '0);
    ack_i = 16'hFFFF; ack_we_i = 1'b1;
    @(negedge clk);
    ack_i = '0; ack_we_i = 1'b0;
    @(negedge clk);
    check("R10 ended early", T'(irq_o), 16'h0001);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule